// File: doc/BRIEF.md
# Active Priority Tracker with Non-Maskable Flag

This block records which interrupt priorities are currently active for one virtual CPU interface. It holds two banks of active-priority bits, one for group 0 and one for group 1. Each bank is a set of 32-bit words, one bit per priority slot. Every group-1 word also carries a non-maskable (NMI) flag. The running priority is rebuilt every cycle from the banks. Its low byte gives the most urgent active priority, and bit 63 shows that the group-1 word supplying it holds an NMI activation.

Interrupt acknowledge logic pulses `act_vld` to mark a priority active. End-of-interrupt logic pulses `drop_vld` to remove the most urgent active priority, and then reads back the value that was dropped on `drop_prio`. Save and restore logic loads whole words through the direct write port. `min_bpr` sets how many priority bits are significant: a priority maps to slot `prio >> (min_bpr+1)`, and a slot maps back to a priority as `slot << (min_bpr+1)`.

The block has no state machine. All state is in the two banks and the `drop_prio` register. The flow has three strobes, which are resolved by a fixed precedence (R10): drop wins over activate, and activate wins over write. These are the only transitions.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset, every bank word and flag is clear, `rpr` equals 0xFF with all other bits zero, and `drop_prio` equals 0xFF.
- R2: `rpr[7:0]` is computed as follows. Scan the words in ascending order over the OR of both banks. Take the first non-zero word w and the position b of its lowest set bit. The result is ((w*32+b) << (min_bpr+1)), truncated to 8 bits. Bits 62:8 are zero.
- R3: When no bit in 31:0 of any word in either bank is set, `rpr` is exactly 0xFF.
- R4: `rpr[63]` is 1 only if all of these hold: NMI_EN is 1, some bit is active, and the group-1 flag of the word w from R2 is set.
- R5: An activation sets bank `act_grp` (0 = group 0, 1 = group 1) word s/32, bit s%32, where s = act_prio >> (min_bpr+1). When NMI_EN is 1, `act_grp` is 1 and `act_nmi` is 1, it also sets that word's flag. `act_nmi` has no effect on group 0.
- R6: A direct write replaces bits 31:0 of word `wr_word` in bank `wr_grp` with `wr_data[31:0]`. For group 1 with NMI_EN set, the flag is loaded from `wr_data[63]`. `wr_data[62:32]` is ignored.
- R7: A drop finds the lowest set slot in each bank and takes the lower one, with group 0 winning a tie. It clears that slot, and from the next cycle `drop_prio` equals (slot << (min_bpr+1)) truncated to 8 bits.
- R8: A drop taken from a group-1 word also clears that word's flag.
- R9: A drop while both banks are empty changes no bank state and sets `drop_prio` to 0xFF.
- R10: When strobes coincide, only one takes effect: drop first, then activate, then write.
- R11: `drop_prio` holds its value in every cycle without a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_bpr | input | 3 | Minimum binary point; shift amount is min_bpr+1 |
| act_vld | input | 1 | Activate strobe |
| act_prio | input | 8 | Priority being activated |
| act_grp | input | 1 | Group of the activation (1 = group 1) |
| act_nmi | input | 1 | Activation is non-maskable |
| drop_vld | input | 1 | Priority-drop strobe |
| wr_vld | input | 1 | Direct word write strobe |
| wr_grp | input | 1 | Bank written (1 = group 1) |
| wr_word | input | 2 | Word index written |
| wr_data | input | 64 | Write data; bits 31:0 are the slots, bit 63 is the flag |
| rpr | output | 64 | Running priority; bit 63 is the NMI indicator |
| drop_prio | output | 8 | Priority removed by the last drop |

## Verification
The bench builds two copies with the default four words and 8-bit priorities, one with NMI_EN=1 and one with NMI_EN=0, and drives both with the same stimulus. Comparing the two copies shows that the flag path can be switched off: activations and writes that carry the flag must raise bit 63 in one copy and never in the other. Four words cover every slot that an 8-bit priority can reach at min_bpr=0. Varying min_bpr up to 7 covers both truncation in the slot-to-priority shift and slots in the upper words that only direct writes can set.

// File: rtl/apt_pkg.sv
package apt_pkg;

    // Position of the least significant set bit; 0 when the word is empty.
    function automatic logic [4:0] low_set_bit(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/apt_scan.sv
module apt_scan #(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 7,
    parameter int WSEL_W    = 2
) (
    input  logic [NUM_WORDS-1:0][31:0] words,
    output logic                       found,
    output logic [IDX_W-1:0]           slot,
    output logic [WSEL_W-1:0]          wsel
);
    import apt_pkg::*;

    // Walk downwards so the lowest non-empty word is the last one assigned.
    always_comb begin
        found = 1'b0;
        slot  = '0;
        wsel  = '0;
        for (int w = NUM_WORDS - 1; w >= 0; w--) begin
            if (words[w] != 32'd0) begin
                found = 1'b1;
                wsel  = WSEL_W'(w);
                slot  = IDX_W'(w * 32 + int'(low_set_bit(words[w])));
            end
        end
    end
endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
    parameter int NUM_WORDS = 4,
    parameter int WSEL_W    = 2,
    parameter bit HAS_FLAG  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [WSEL_W-1:0]          set_word,
    input  logic [4:0]                 set_bit,
    input  logic                       set_flag,
    input  logic                       clr_en,
    input  logic [WSEL_W-1:0]          clr_word,
    input  logic                       wr_en,
    input  logic [WSEL_W-1:0]          wr_word,
    input  logic [31:0]                wr_bits,
    input  logic                       wr_flag,
    output logic [NUM_WORDS-1:0][31:0] words,
    output logic [NUM_WORDS-1:0]       flags
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (clr_en && clr_word == WSEL_W'(w)) begin
                words[w] <= words[w] & (words[w] - 32'd1);
            end else if (set_en && set_word == WSEL_W'(w)) begin
                words[w] <= words[w] | (32'd1 << set_bit);
            end else if (wr_en && wr_word == WSEL_W'(w)) begin
                words[w] <= wr_bits;
            end
        end

        if (HAS_FLAG) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[w] <= 1'b0;
                end else if (clr_en && clr_word == WSEL_W'(w)) begin
                    flags[w] <= 1'b0;
                end else if (set_en && set_word == WSEL_W'(w)) begin
                    flags[w] <= flags[w] | set_flag;
                end else if (wr_en && wr_word == WSEL_W'(w)) begin
                    flags[w] <= wr_flag;
                end
            end
        end else begin : g_noflag
            assign flags[w] = 1'b0;
        end
    end

    if (!HAS_FLAG) begin : g_sink
        logic flag_in_unused;
        assign flag_in_unused = set_flag ^ wr_flag;
    end

    // R6
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !wr_en) |=> $countones(flags) <= $past($countones(flags)));

    // R8
    drop_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && flags[clr_word]) |=> $countones(flags) == $past($countones(flags)) - 1);
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker #(
    parameter int NUM_WORDS = 4,
    parameter int PRIO_W    = 8,
    parameter bit NMI_EN    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           min_bpr,
    input  logic                 act_vld,
    input  logic [PRIO_W-1:0]    act_prio,
    input  logic                 act_grp,
    input  logic                 act_nmi,
    input  logic                 drop_vld,
    input  logic                 wr_vld,
    input  logic                 wr_grp,
    input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] wr_word,
    input  logic [63:0]          wr_data,
    output logic [63:0]          rpr,
    output logic [PRIO_W-1:0]    drop_prio
);
    localparam int WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int IDX_W  = $clog2(NUM_WORDS * 32);
    localparam int WIDE_W = IDX_W + PRIO_W + 1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    logic [3:0] shamt;
    assign shamt = {1'b0, min_bpr} + 4'd1;

    function automatic logic [PRIO_W-1:0] slot_to_prio(input logic [IDX_W-1:0] s,
                                                       input logic [3:0] sh);
        logic [WIDE_W-1:0] t;
        t = WIDE_W'(s) << sh;
        return t[PRIO_W-1:0];
    endfunction

    // Activation decode and strobe precedence: drop > activate > write.
    logic [PRIO_W-1:0] act_slot;
    logic              act_in_range, act_go, wr_go;
    assign act_slot     = act_prio >> shamt;
    assign act_in_range = int'(act_slot >> 5) < NUM_WORDS;
    assign act_go       = act_vld && !drop_vld && act_in_range;
    assign wr_go        = wr_vld && !drop_vld && !act_vld;

    logic wr_mid_unused;
    assign wr_mid_unused = ^wr_data[62:32];

    // Banks and scanners.
    logic [1:0][NUM_WORDS-1:0][31:0] bank_words;
    logic [1:0][NUM_WORDS-1:0]       bank_flags;
    logic [2:0][NUM_WORDS-1:0][31:0] scan_in;
    logic [2:0]                      scan_found;
    logic [2:0][IDX_W-1:0]           scan_slot;
    logic [2:0][WSEL_W-1:0]          scan_wsel;
    logic                            drop_any, pick_g1;

    assign scan_in[0] = bank_words[0];
    assign scan_in[1] = bank_words[1];
    assign scan_in[2] = bank_words[0] | bank_words[1];

    for (genvar s = 0; s < 3; s++) begin : g_scan
        apt_scan #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_scan (
            .words (scan_in[s]),
            .found (scan_found[s]),
            .slot  (scan_slot[s]),
            .wsel  (scan_wsel[s])
        );
    end

    assign drop_any = scan_found[0] || scan_found[1];
    assign pick_g1  = scan_found[1] && (!scan_found[0] || scan_slot[1] < scan_slot[0]);

    for (genvar g = 0; g < 2; g++) begin : g_bank
        apt_bank #(
            .NUM_WORDS (NUM_WORDS),
            .WSEL_W    (WSEL_W),
            .HAS_FLAG  ((g == 1) && NMI_EN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (act_go && (act_grp == g[0])),
            .set_word (WSEL_W'(act_slot >> 5)),
            .set_bit  (act_slot[4:0]),
            .set_flag (act_nmi),
            .clr_en   (drop_vld && drop_any && (pick_g1 == g[0])),
            .clr_word (scan_wsel[g]),
            .wr_en    (wr_go && (wr_grp == g[0])),
            .wr_word  (wr_word),
            .wr_bits  (wr_data[31:0]),
            .wr_flag  (wr_data[63]),
            .words    (bank_words[g]),
            .flags    (bank_flags[g])
        );
    end

    // Dropped priority register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_prio <= IDLE_PRIO;
        end else if (drop_vld) begin
            drop_prio <= drop_any ? slot_to_prio(pick_g1 ? scan_slot[1] : scan_slot[0], shamt)
                                  : IDLE_PRIO;
        end
    end

    // Running priority.
    logic [PRIO_W-1:0] run_prio;
    logic              run_nmi;
    always_comb begin
        run_prio = IDLE_PRIO;
        run_nmi  = 1'b0;
        if (scan_found[2]) begin
            run_prio = slot_to_prio(scan_slot[2], shamt);
            run_nmi  = NMI_EN && bank_flags[1][scan_wsel[2]];
        end
    end
    assign rpr = {run_nmi, {(63 - PRIO_W){1'b0}}, run_prio};

    // R5
    act_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> (bank_words != '0));

    // R7
    drop_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_vld && drop_any) |=> $countones(bank_words) == $past($countones(bank_words)) - 1);

    // R9
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_vld && !drop_any) |=> ($stable(bank_words) && drop_prio == IDLE_PRIO));

    // R4
    nmi_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpr[63] |-> rpr[PRIO_W-1:0] != IDLE_PRIO);

    // R11
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_vld |=> $stable(drop_prio));
endmodule

// File: tb/active_prio_tracker_bench.sv
module active_prio_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  min_bpr = 3'd0;
    logic        act_vld = 1'b0, act_grp = 1'b0, act_nmi = 1'b0;
    logic [7:0]  act_prio = 8'd0;
    logic        drop_vld = 1'b0, wr_vld = 1'b0, wr_grp = 1'b0;
    logic [1:0]  wr_word = 2'd0;
    logic [63:0] wr_data = 64'd0;
    logic [63:0] rpr_a, rpr_b;
    logic [7:0]  dp_a, dp_b;

    always #2 clk = ~clk;

    active_prio_tracker #(.NMI_EN(1'b1)) u_active_prio_tracker (
        .clk(clk), .rst_n(rst_n), .min_bpr(min_bpr), .act_vld(act_vld), .act_prio(act_prio),
        .act_grp(act_grp), .act_nmi(act_nmi), .drop_vld(drop_vld), .wr_vld(wr_vld),
        .wr_grp(wr_grp), .wr_word(wr_word), .wr_data(wr_data), .rpr(rpr_a), .drop_prio(dp_a));

    active_prio_tracker #(.NMI_EN(1'b0)) u_active_prio_tracker_nonmi (
        .clk(clk), .rst_n(rst_n), .min_bpr(min_bpr), .act_vld(act_vld), .act_prio(act_prio),
        .act_grp(act_grp), .act_nmi(act_nmi), .drop_vld(drop_vld), .wr_vld(wr_vld),
        .wr_grp(wr_grp), .wr_word(wr_word), .wr_data(wr_data), .rpr(rpr_b), .drop_prio(dp_b));

    int nchk = 0, nerr = 0;
    logic [31:0] mg0 [4];
    logic [31:0] mg1 [4];
    logic        mf  [4];
    logic [7:0]  mdp;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [63:0] exp_rpr(input bit nmi_on, input int bpr);
        logic [63:0] r;
        r = 64'hFF;
        for (int w = 0; w < 4; w++) begin
            if ((mg0[w] | mg1[w]) != 0) begin
                r = 64'(((w * 32 + lowest(mg0[w] | mg1[w])) << (bpr + 1)) & 255);
                if (nmi_on && mf[w]) r[63] = 1'b1;
                return r;
            end
        end
        return r;
    endfunction

    function automatic void model_reset();
        for (int w = 0; w < 4; w++) begin mg0[w] = 0; mg1[w] = 0; mf[w] = 0; end
        mdp = 8'hFF;
    endfunction

    function automatic void model_step(input bit a_v, input int a_p, input bit a_g, input bit a_n,
                                       input bit d_v, input bit w_v, input bit w_g, input int w_w,
                                       input logic [63:0] w_d, input int bpr);
        if (d_v) begin
            int s0 = 999, s1 = 999, w0 = 0, w1 = 0;
            for (int w = 3; w >= 0; w--) begin
                if (mg0[w] != 0) begin s0 = w * 32 + lowest(mg0[w]); w0 = w; end
                if (mg1[w] != 0) begin s1 = w * 32 + lowest(mg1[w]); w1 = w; end
            end
            if (s0 == 999 && s1 == 999) mdp = 8'hFF;
            else if (s0 <= s1) begin
                mg0[w0] = mg0[w0] & ~(32'd1 << (s0 % 32));
                mdp = 8'((s0 << (bpr + 1)) & 255);
            end else begin
                mg1[w1] = mg1[w1] & ~(32'd1 << (s1 % 32));
                mf[w1] = 1'b0;
                mdp = 8'((s1 << (bpr + 1)) & 255);
            end
        end else if (a_v) begin
            int s = a_p >> (bpr + 1);
            if (s / 32 < 4) begin
                if (a_g) begin
                    mg1[s / 32] = mg1[s / 32] | (32'd1 << (s % 32));
                    if (a_n) mf[s / 32] = 1'b1;
                end else mg0[s / 32] = mg0[s / 32] | (32'd1 << (s % 32));
            end
        end else if (w_v) begin
            if (w_g) begin mg1[w_w] = w_d[31:0]; mf[w_w] = w_d[63]; end
            else mg0[w_w] = w_d[31:0];
        end
    endfunction

    // One clock of stimulus, model update, then comparison of both copies.
    task automatic step(input string tag, input bit a_v, input int a_p, input bit a_g, input bit a_n,
                        input bit d_v, input bit w_v, input bit w_g, input int w_w,
                        input logic [63:0] w_d, input int bpr);
        act_vld = a_v; act_prio = 8'(a_p); act_grp = a_g; act_nmi = a_n;
        drop_vld = d_v; wr_vld = w_v; wr_grp = w_g; wr_word = 2'(w_w); wr_data = w_d;
        min_bpr = 3'(bpr);
        @(posedge clk);
        model_step(a_v, a_p, a_g, a_n, d_v, w_v, w_g, w_w, w_d, bpr);
        @(negedge clk);
        act_vld = 0; drop_vld = 0; wr_vld = 0;
        check({tag, " rpr nmi"}, rpr_a, exp_rpr(1'b1, bpr));
        check({tag, " rpr plain"}, rpr_b, exp_rpr(1'b0, bpr));
        check({tag, " drop_prio"}, {56'd0, dp_a}, {56'd0, mdp});
        check({tag, " drop_prio plain"}, {56'd0, dp_b}, {56'd0, mdp});
    endtask

    bit done = 0;
    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R3 reset state
        check("R1 rpr", rpr_a, 64'hFF);
        check("R1 drop_prio", {56'd0, dp_a}, 64'hFF);
        // R9 drop on empty
        step("R9 empty drop", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R5 R4 group-1 NMI activation: slot 32 -> 0x40 with flag
        step("R5 act g1 nmi", 1, 8'h40, 1, 1, 0, 0, 0, 0, 0, 0);
        check("R4 nmi bit", rpr_a, 64'h8000_0000_0000_0040);
        check("R4 plain no nmi", rpr_b, 64'h40);
        // R5 act_nmi ignored for group 0; R2 slot 8 wins
        step("R5 act g0", 1, 8'h10, 0, 1, 0, 0, 0, 0, 0, 0);
        check("R2 lower word wins", rpr_a, 64'h10);
        // R7 group 0 lower slot dropped
        step("R7 drop g0", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R7 dropped 0x10", {56'd0, dp_a}, 64'h10);
        // R8 drop of the flagged word clears flag
        step("R8 drop g1", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R8 idle after drop", rpr_a, 64'hFF);
        // R11 hold
        step("R11 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R7 tie: group 0 wins
        step("R7 tie a", 1, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R7 tie b", 1, 8'h20, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R7 tie drop", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R7 tie g1 remains", rpr_a, 64'h8000_0000_0000_0020);
        step("R7 tie drop2", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R2 binary point scaling: 0x64 at bpr 2 -> slot 12
        step("R2 act bpr2", 1, 8'h64, 1, 0, 0, 0, 0, 0, 0, 2);
        check("R2 bpr2 value", rpr_a, 64'h60);
        step("R2 bpr0 view", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R2 bpr0 value", rpr_a, 64'h18);
        // R6 direct write: flag and junk in 62:32
        step("R6 write flag", 0, 0, 0, 0, 0, 1, 1, 2, 64'hFFFF_FFFF_0000_0000, 0);
        step("R6 clear word0", 0, 0, 0, 0, 0, 1, 1, 0, 64'h0, 0);
        check("R3 R4 flag alone idle", rpr_a, 64'hFF);
        step("R6 act word2", 1, 8'h80, 1, 0, 0, 0, 0, 0, 0, 0);
        check("R6 written flag shown", rpr_a, 64'h8000_0000_0000_0080);
        check("R6 plain flag dropped", rpr_b, 64'h80);
        // R10 precedence
        step("R10 drop over act", 1, 8'h02, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R10 act over write", 1, 8'h04, 0, 0, 0, 1, 0, 0, 64'hFFFF_FFFF, 0);
        check("R10 act kept", rpr_a, 64'h04);
        step("R10 all three", 1, 8'h06, 1, 1, 1, 1, 0, 1, 64'h1, 0);
        // Random traffic (R2 R4 R5 R6 R7 R8 R10 R11)
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 100);
            int bpr = ($urandom % 8 == 0) ? int'($urandom % 8) : int'($urandom % 3);
            logic [63:0] d = {$urandom, $urandom};
            d[31:0] = d[31:0] & $urandom & $urandom;
            step("R2 R4 R7 random", r < 45, int'($urandom % 256), 1'($urandom), 1'($urandom),
                 r >= 45 && r < 80, (r >= 75) || (r < 5), 1'($urandom), int'($urandom % 4),
                 d, bpr);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule